// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides, in a single clock cycle, whether the core must leave its current instruction stream for an exception, or whether it must come back from one. It looks at every exception source at once, picks the most urgent accepted source, and produces three results together: the fixed vector address to load into the PC, the new status word, and a PC-load strobe. In the same step it records the interrupted status word and the return address in a saved-status register and a link register. There is one such pair for each privileged mode.

The pipeline presents the current PC, the current status word, and the word being executed. The block recognises a software-trap instruction from that word and always exposes the word's 24-bit service number for handler code. A return request reloads the PC from the link register of the current mode and restores that mode's saved status in the same cycle. The banked pair for the mode in the current status word is always visible on two read ports.

Status word layout: bits 4:0 hold the mode, bit 6 is the fast-interrupt mask (F), and bit 7 is the normal-interrupt mask (I).

Top module: `exc_entry_ctrl`

## Requirements
- R1: An exception entry drives `next_pc` to a fixed vector: reset 0x00, undefined 0x04, software trap 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. The address 0x14 is never produced.
- R2: When several sources are active together, exactly one is taken. The order, highest first, is: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software trap.
- R3: A software trap is recognised when `exec_valid` is high and `instr_word[27:24]` equals 4'b1111. Bits 31:28 play no part in this. `swi_imm` always equals `instr_word[23:0]`.
- R4: A non-reset entry writes two banked registers of the target mode, which become visible from the next cycle:
  - the saved-status register takes `cur_psr`;
  - the link register takes `cur_pc` with bits 1:0 cleared, plus 4.
- R5: On a non-reset entry, `psr_next` copies `cur_psr` with these changes:
  - bits 4:0 become the target mode;
  - bit 7 is set;
  - bit 6 is set for FIQ and otherwise copied.
- R6: IRQ is taken only while `cur_psr[7]` is 0. FIQ is taken only while `cur_psr[6]` is 0.
- R7: A reset request gives `next_pc` 0 and `psr_next` 0x000000D3 (supervisor mode, both masks set). It writes no banked register.
- R8: A return request, when no exception is taken and the current mode is banked, sets `pc_load`. In that case `next_pc` is the current link register with bits 1:0 cleared, and `psr_next` is the current saved status. In user mode, or in an unlisted mode, a return request has no effect.
- R9: Mode codes are: user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111 (both aborts), undefined 11011. `spsr_view` and `lr_view` show the bank selected by `cur_psr[4:0]`, and read 0 for user or unlisted modes.
- R10: While `rst_n` is low, every banked register reads 0.
- R11: `psr_we` equals `pc_load`. Both are 0 when no exception is taken and no return is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Core reset exception request |
| exec_valid | input | 1 | `instr_word` is being executed this cycle |
| instr_word | input | 32 | Instruction in execute |
| undef_flag | input | 1 | Undefined opcode detected |
| pabort_flag | input | 1 | Prefetch abort on current instruction |
| dabort_flag | input | 1 | Data abort from a load/store |
| irq_req | input | 1 | Normal interrupt request line |
| fiq_req | input | 1 | Fast interrupt request line |
| ret_req | input | 1 | Return with status restore |
| cur_pc | input | 32 | PC of the current instruction |
| cur_psr | input | 32 | Current status word |
| pc_load | output | 1 | Load `next_pc` into the PC |
| next_pc | output | 32 | Vector or return address |
| psr_we | output | 1 | Write `psr_next` into the status word |
| psr_next | output | 32 | New status word |
| swi_hit | output | 1 | Software-trap encoding recognised |
| swi_imm | output | 24 | Service number field of `instr_word` |
| spsr_view | output | 32 | Saved status of the current mode |
| lr_view | output | 32 | Link register of the current mode |

## Verification
Two functions can fall in the same cycle, and the bench provokes both kinds of overlap:
- A return request together with an accepted exception. The exception must win, and the return must leave no trace.
- Two interrupt lines together with a masked status word. A masked line must never steal priority from a lower source.

Random cycles overlap all sources with independent masks and modes, and directed cycles peel the sources away one by one from an all-active start. Each cycle is judged against a bench model of the priority order and of the five banks. The banks are read back through the view ports by choosing the mode in `cur_psr` in later cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int MODE_W = 5;
  localparam int NBANK  = 5;
  localparam int BIDX_W = $clog2(NBANK);
  localparam int IBIT   = 7;
  localparam int FBIT   = 6;

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;

  typedef enum logic [2:0] {
    EK_NONE, EK_RESET, EK_UNDEF, EK_SWI, EK_PABT, EK_DABT, EK_IRQ, EK_FIQ
  } exc_kind_e;

  function automatic logic [7:0] vec_off(exc_kind_e k);
    case (k)
      EK_UNDEF: return 8'h04;
      EK_SWI:   return 8'h08;
      EK_PABT:  return 8'h0C;
      EK_DABT:  return 8'h10;
      EK_IRQ:   return 8'h18;
      EK_FIQ:   return 8'h1C;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(exc_kind_e k);
    case (k)
      EK_FIQ:          return M_FIQ;
      EK_IRQ:          return M_IRQ;
      EK_PABT, EK_DABT: return M_ABT;
      EK_UNDEF:        return M_UND;
      default:         return M_SVC;
    endcase
  endfunction

  function automatic logic bank_ok(logic [MODE_W-1:0] m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  function automatic logic [BIDX_W-1:0] bank_sel(logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return BIDX_W'(0);
      M_IRQ:   return BIDX_W'(1);
      M_SVC:   return BIDX_W'(2);
      M_ABT:   return BIDX_W'(3);
      default: return BIDX_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/exc_swi_decode.sv
module exc_swi_decode #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 24
) (
  input  logic             exec_valid,
  input  logic [XLEN-1:0]  instr_word,
  output logic             swi_hit,
  output logic [IMM_W-1:0] swi_imm
);
  localparam int OP_LO = IMM_W;
  localparam int OP_HI = IMM_W + 3;

  always_comb begin
    swi_hit = exec_valid && (instr_word[OP_HI:OP_LO] == 4'b1111);
    swi_imm = instr_word[IMM_W-1:0];
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      rst_req,
  input  logic      undef_f,
  input  logic      swi_f,
  input  logic      pabt_f,
  input  logic      dabt_f,
  input  logic      irq_f,
  input  logic      fiq_f,
  input  logic      i_mask,
  input  logic      f_mask,
  output exc_kind_e kind
);
  always_comb begin
    if (rst_req)                 kind = EK_RESET;
    else if (dabt_f)             kind = EK_DABT;
    else if (fiq_f && !f_mask)   kind = EK_FIQ;
    else if (irq_f && !i_mask)   kind = EK_IRQ;
    else if (pabt_f)             kind = EK_PABT;
    else if (undef_f)            kind = EK_UNDEF;
    else if (swi_f)              kind = EK_SWI;
    else                         kind = EK_NONE;
  end
endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
  parameter int XLEN   = 32,
  parameter int NBANK  = 5,
  parameter int BIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BIDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_spsr,
  input  logic [XLEN-1:0]   wr_lr,
  input  logic              rd_ok,
  input  logic [BIDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]   rd_spsr,
  output logic [XLEN-1:0]   rd_lr
);
  logic [XLEN-1:0] spsr_q [NBANK];
  logic [XLEN-1:0] lr_q   [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic            en;
    logic [XLEN-1:0] spsr_d;
    logic [XLEN-1:0] lr_d;

    always_comb begin
      en     = wr_en && (wr_idx == BIDX_W'(b));
      spsr_d = wr_spsr;
      lr_d   = wr_lr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        spsr_q[b] <= '0;
        lr_q[b]   <= '0;
      end else if (en) begin
        spsr_q[b] <= spsr_d;
        lr_q[b]   <= lr_d;
      end
    end
  end

  always_comb begin
    rd_spsr = '0;
    rd_lr   = '0;
    if (rd_ok && (int'(rd_idx) < NBANK)) begin
      rd_spsr = spsr_q[rd_idx];
      rd_lr   = lr_q[rd_idx];
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_req,
  input  logic             exec_valid,
  input  logic [XLEN-1:0]  instr_word,
  input  logic             undef_flag,
  input  logic             pabort_flag,
  input  logic             dabort_flag,
  input  logic             irq_req,
  input  logic             fiq_req,
  input  logic             ret_req,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  cur_psr,
  output logic             pc_load,
  output logic [XLEN-1:0]  next_pc,
  output logic             psr_we,
  output logic [XLEN-1:0]  psr_next,
  output logic             swi_hit,
  output logic [IMM_W-1:0] swi_imm,
  output logic [XLEN-1:0]  spsr_view,
  output logic [XLEN-1:0]  lr_view
);
  localparam logic [XLEN-1:0] RESET_PSR = XLEN'({1'b1, 1'b1, 1'b0, M_SVC});

  exc_kind_e         kind;
  logic              take_exc;
  logic              take_ret;
  logic [MODE_W-1:0] cur_mode;
  logic [MODE_W-1:0] tgt_mode;
  logic              rd_ok;
  logic [BIDX_W-1:0] rd_idx;
  logic              bank_we;
  logic [BIDX_W-1:0] bank_widx;
  logic [XLEN-1:0]   pc_word;
  logic [XLEN-1:0]   link_val;
  logic [XLEN-1:0]   entry_psr;

  exc_swi_decode #(.XLEN(XLEN), .IMM_W(IMM_W)) u_swi (
    .exec_valid (exec_valid),
    .instr_word (instr_word),
    .swi_hit    (swi_hit),
    .swi_imm    (swi_imm)
  );

  exc_arbiter u_arb (
    .rst_req (reset_req),
    .undef_f (undef_flag),
    .swi_f   (swi_hit),
    .pabt_f  (pabort_flag),
    .dabt_f  (dabort_flag),
    .irq_f   (irq_req),
    .fiq_f   (fiq_req),
    .i_mask  (cur_psr[IBIT]),
    .f_mask  (cur_psr[FBIT]),
    .kind    (kind)
  );

  always_comb begin
    cur_mode  = cur_psr[MODE_W-1:0];
    rd_ok     = bank_ok(cur_mode);
    rd_idx    = bank_sel(cur_mode);
    tgt_mode  = mode_of(kind);
    take_exc  = (kind != EK_NONE);
    take_ret  = ret_req && !take_exc && rd_ok;
    bank_we   = take_exc && (kind != EK_RESET);
    bank_widx = bank_sel(tgt_mode);
    pc_word   = {cur_pc[XLEN-1:2], 2'b00};
    link_val  = pc_word + XLEN'(4);
  end

  exc_bank #(.XLEN(XLEN), .NBANK(NBANK), .BIDX_W(BIDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_we),
    .wr_idx  (bank_widx),
    .wr_spsr (cur_psr),
    .wr_lr   (link_val),
    .rd_ok   (rd_ok),
    .rd_idx  (rd_idx),
    .rd_spsr (spsr_view),
    .rd_lr   (lr_view)
  );

  always_comb begin
    entry_psr                 = cur_psr;
    entry_psr[MODE_W-1:0]     = tgt_mode;
    entry_psr[IBIT]           = 1'b1;
    if (kind == EK_FIQ) entry_psr[FBIT] = 1'b1;
  end

  always_comb begin
    pc_load  = take_exc || take_ret;
    psr_we   = pc_load;
    next_pc  = '0;
    psr_next = cur_psr;
    if (kind == EK_RESET) begin
      next_pc  = '0;
      psr_next = RESET_PSR;
    end else if (take_exc) begin
      next_pc  = XLEN'(vec_off(kind));
      psr_next = entry_psr;
    end else if (take_ret) begin
      next_pc  = {lr_view[XLEN-1:2], 2'b00};
      psr_next = spsr_view;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reset_req,
  input logic             exec_valid,
  input logic [XLEN-1:0]  instr_word,
  input logic             undef_flag,
  input logic             pabort_flag,
  input logic             dabort_flag,
  input logic             irq_req,
  input logic             fiq_req,
  input logic             ret_req,
  input logic [XLEN-1:0]  cur_pc,
  input logic [XLEN-1:0]  cur_psr,
  input logic             pc_load,
  input logic [XLEN-1:0]  next_pc,
  input logic             psr_we,
  input logic [XLEN-1:0]  psr_next,
  input logic             swi_hit,
  input logic [IMM_W-1:0] swi_imm,
  input logic [XLEN-1:0]  spsr_view,
  input logic [XLEN-1:0]  lr_view
);
  logic no_exc_src;
  logic banked_mode;
  always_comb begin
    no_exc_src = !reset_req && !dabort_flag && !pabort_flag && !undef_flag &&
                 !swi_hit && !(irq_req && !cur_psr[7]) && !(fiq_req && !cur_psr[6]);
    banked_mode = (cur_psr[4:0] == 5'b10001) || (cur_psr[4:0] == 5'b10010) ||
                  (cur_psr[4:0] == 5'b10011) || (cur_psr[4:0] == 5'b10111) ||
                  (cur_psr[4:0] == 5'b11011);
  end

  assert_vec_table_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !ret_req) |-> (next_pc[31:5] == '0 && next_pc[1:0] == 2'b00 &&
                               next_pc != 32'h14));

  assert_reset_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (pc_load && next_pc == '0 && psr_next == 32'h0000_00D3));

  assert_trap_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !ret_req && next_pc == 32'h8) |=>
      (cur_psr[4:0] != 5'b10011 ||
       (lr_view == {$past(cur_pc[31:2]), 2'b00} + 32'd4 && spsr_view == $past(cur_psr))));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && cur_psr[7] && !fiq_req && !reset_req && !dabort_flag &&
     !pabort_flag && !undef_flag && !swi_hit && !ret_req) |-> !pc_load);

  assert_entry_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !ret_req) |-> (psr_next[7] && psr_we));

  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && no_exc_src && banked_mode) |->
      (pc_load && psr_next == spsr_view && next_pc == {lr_view[31:2], 2'b00}));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (no_exc_src && !ret_req) |-> (!pc_load && !psr_we));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic        clk;
  logic        rst_n;
  logic        reset_req, exec_valid, undef_flag, pabort_flag, dabort_flag;
  logic        irq_req, fiq_req, ret_req;
  logic [31:0] instr_word, cur_pc, cur_psr;
  logic        pc_load, psr_we, swi_hit;
  logic [31:0] next_pc, psr_next, spsr_view, lr_view;
  logic [23:0] swi_imm;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] m_spsr [5];
  logic [31:0] m_lr   [5];

  exc_entry_ctrl i_exc_entry_ctrl (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int midx(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  // 0 none 1 reset 2 undef 3 trap 4 pabt 5 dabt 6 irq 7 fiq
  function automatic int ref_kind(input logic rr, da, fq, iq, pa, uf, sw,
                                  input logic [31:0] psr);
    if (rr) return 1;
    if (da) return 5;
    if (fq && !psr[6]) return 7;
    if (iq && !psr[7]) return 6;
    if (pa) return 4;
    if (uf) return 2;
    if (sw) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] ref_vec(input int k);
    case (k)
      2: return 32'h04; 3: return 32'h08; 4: return 32'h0C;
      5: return 32'h10; 6: return 32'h18; 7: return 32'h1C;
      default: return 32'h00;
    endcase
  endfunction

  function automatic logic [4:0] ref_mode(input int k);
    case (k)
      2: return 5'b11011; 4, 5: return 5'b10111;
      6: return 5'b10010; 7: return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  task automatic step(input logic rr, input logic ev, input logic [31:0] ins,
                      input logic uf, input logic pa, input logic da,
                      input logic iq, input logic fq, input logic rt,
                      input logic [31:0] pc, input logic [31:0] psr);
    int k, ci;
    logic        exp_sw, exp_ld;
    logic [31:0] exp_pc, exp_psr, exp_sv, exp_lv;
    @(negedge clk);
    reset_req = rr; exec_valid = ev; instr_word = ins; undef_flag = uf;
    pabort_flag = pa; dabort_flag = da; irq_req = iq; fiq_req = fq;
    ret_req = rt; cur_pc = pc; cur_psr = psr;
    #1;
    exp_sw = ev && (ins[27:24] == 4'hF);
    k  = ref_kind(rr, da, fq, iq, pa, uf, exp_sw, psr);
    ci = midx(psr[4:0]);
    exp_sv = (ci >= 0) ? m_spsr[ci] : 32'h0;
    exp_lv = (ci >= 0) ? m_lr[ci]   : 32'h0;
    exp_ld = 1'b0; exp_pc = 32'h0; exp_psr = psr;
    if (k == 1) begin
      exp_ld = 1'b1; exp_psr = 32'h0000_00D3;
    end else if (k != 0) begin
      exp_ld = 1'b1; exp_pc = ref_vec(k);
      exp_psr = {psr[31:8], 1'b1, (k == 7) ? 1'b1 : psr[6], psr[5], ref_mode(k)};
    end else if (rt && ci >= 0) begin
      exp_ld = 1'b1; exp_pc = {exp_lv[31:2], 2'b00}; exp_psr = exp_sv;
    end
    chk(swi_hit == exp_sw, "R3 swi_hit", {31'h0, swi_hit}, {31'h0, exp_sw});
    chk(swi_imm == ins[23:0], "R3 swi_imm", {8'h0, swi_imm}, {8'h0, ins[23:0]});
    chk(pc_load == exp_ld, "R2/R8/R11 pc_load", {31'h0, pc_load}, {31'h0, exp_ld});
    chk(psr_we == exp_ld, "R11 psr_we", {31'h0, psr_we}, {31'h0, exp_ld});
    if (exp_ld) begin
      chk(next_pc == exp_pc, "R1/R2/R6/R8 next_pc", next_pc, exp_pc);
      chk(psr_next == exp_psr, "R5/R7/R8 psr_next", psr_next, exp_psr);
    end
    chk(spsr_view == exp_sv, "R4/R9 spsr_view", spsr_view, exp_sv);
    chk(lr_view == exp_lv, "R4/R9 lr_view", lr_view, exp_lv);
    if (k >= 2) begin
      m_spsr[midx(ref_mode(k))] = psr;
      m_lr[midx(ref_mode(k))]   = {pc[31:2], 2'b00} + 32'd4;
    end
  endtask

  task automatic quiet(input logic [31:0] psr);
    step(0, 0, 32'h0, 0, 0, 0, 0, 0, 0, 32'h100, psr);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int b = 0; b < 5; b++) begin m_spsr[b] = '0; m_lr[b] = '0; end
    reset_req = 0; exec_valid = 0; instr_word = 0; undef_flag = 0;
    pabort_flag = 0; dabort_flag = 0; irq_req = 0; fiq_req = 0; ret_req = 0;
    cur_pc = 0;
    foreach (m_spsr[b]) begin
      cur_psr = {24'h0, 3'b110, (b == 0) ? 5'b10001 : (b == 1) ? 5'b10010 :
                 (b == 2) ? 5'b10011 : (b == 3) ? 5'b10111 : 5'b11011};
      #1;
      chk(spsr_view == 0 && lr_view == 0, "R10 bank cleared", spsr_view | lr_view, 32'h0);
    end
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [4:0] pick_mode(input int r);
    case (r % 7)
      0: return 5'b10000; 1: return 5'b10001; 2: return 5'b10010;
      3: return 5'b10011; 4: return 5'b10111; 5: return 5'b11011;
      default: return 5'b00101;
    endcase
  endfunction

  initial begin
    #(2_000_000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    s = $urandom(32'h5EED_1234);
    rst_n = 1'b0;
    hw_reset();
    // R11 idle, R9 user mode views zero
    quiet(32'h0000_0010);
    // R3 trap from user; condition bits differ
    step(0, 1, 32'h3F00_0123, 0, 0, 0, 0, 0, 0, 32'h0000_1002, 32'h0000_0010);
    // R4 bank visible in supervisor mode
    quiet(32'h0000_0093);
    // R8 return restores
    step(0, 0, 32'h0, 0, 0, 0, 0, 0, 1, 32'h0, 32'h0000_0093);
    // R8 return in user mode ignored
    step(0, 0, 32'h0, 0, 0, 0, 0, 0, 1, 32'h40, 32'h0000_0010);
    // R3 opcode not trap, exec_valid low
    step(0, 1, 32'hEE00_0055, 0, 0, 0, 0, 0, 0, 32'h44, 32'h10);
    step(0, 0, 32'hEF00_0055, 0, 0, 0, 0, 0, 0, 32'h44, 32'h10);
    // R2 peel priority
    step(1, 1, 32'hEF00_0001, 1, 1, 1, 1, 1, 1, 32'h200, 32'h10);
    step(0, 1, 32'hEF00_0001, 1, 1, 1, 1, 1, 1, 32'h200, 32'h10);
    step(0, 1, 32'hEF00_0001, 1, 1, 0, 1, 1, 1, 32'h204, 32'h10);
    step(0, 1, 32'hEF00_0001, 1, 1, 0, 1, 0, 1, 32'h208, 32'h10);
    step(0, 1, 32'hEF00_0001, 1, 1, 0, 0, 0, 0, 32'h20C, 32'h10);
    step(0, 1, 32'hEF00_0001, 1, 0, 0, 0, 0, 0, 32'h210, 32'h10);
    // R6 masked lines
    step(0, 0, 32'h0, 0, 0, 0, 1, 1, 0, 32'h300, 32'h0000_00D0);
    step(0, 0, 32'h0, 0, 0, 0, 1, 1, 0, 32'h300, 32'h0000_0090);
    step(0, 0, 32'h0, 0, 0, 0, 1, 1, 0, 32'h300, 32'h0000_0050);
    // R7 reset exception does not touch banks
    step(1, 0, 32'h0, 0, 0, 0, 0, 0, 0, 32'h400, 32'hF000_0012);
    quiet(32'h0000_0012);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ins, psr;
      ins = $urandom();
      if ($urandom_range(0, 3) == 0) ins[27:24] = 4'hF;
      psr = $urandom();
      psr[4:0] = pick_mode($urandom_range(0, 6));
      step($urandom_range(0, 40) == 0, $urandom_range(0, 1) == 1, ins,
           $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 12) == 0, $urandom_range(0, 4) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0,
           $urandom(), psr);
      if (n == 1500) hw_reset();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule